// File: doc/BRIEF.md
# Byte-Accessed 32-bit Alarm Counter

This block is a free-running 32-bit counter with three 32-bit compare channels. Software reaches it over an 8-bit register bus. The counter advances by one on each pulse of a slow tick-enable input, which stands in for a 32.768 kHz clock, and only while the run bit in the control register is set. When the counter wraps it raises an overflow flag. When it steps onto a compare value it raises that channel's match flag. Each flag has a mask bit, and the interrupt line is the OR of every flag that is both set and unmasked.

Every 32-bit register is moved through one shared 32-bit holding register, so a multi-byte access is atomic:
- Reading the low byte captures the whole value, and the upper bytes are then read from that copy.
- Writing the upper bytes only fills the holding register, and writing the low byte commits all four bytes at once.

A counter write does not take effect at once. It is applied on the next tick, and a busy bit in the status register stays set until the tick after that. Software polls the busy bit before it relies on the new count.

Register map (byte addresses):
- 0x00: control (bit0 = run).
- 0x01: status.
- 0x02: mask.
- 0x04–0x07: counter.
- 0x08–0x0B, 0x0C–0x0F and 0x10–0x13: compare channels 0, 1 and 2.

Top module: `slow_alarm_counter`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` is low.
- R2: The counter increments by one on each cycle with `tick_en` high while control bit0 is 1. While that bit is 0, ticks leave the count unchanged and the register contents stay as they are.
- R3: On an increment from 0xFFFFFFFF the counter becomes 0 and status bit0 (overflow) is set.
- R4: Reading the low byte of the counter or of a compare register (offset 0 of its group) returns the live low byte. The same read copies all 32 bits into the holding register, and reads at offsets 1–3 return bytes 1–3 of that copy.
- R5: A write at offset 1–3 of a 32-bit register changes only the holding register. A write at offset 0 loads {holding[31:8], data} into that register. Because the holding register is shared, a low-byte read of another register in between replaces the upper bytes that were written.
- R6: A counter commit sets status bit7 (busy) in the same cycle. The counter takes the committed value on the first tick after the commit, and busy clears on the second tick. Loading the value sets no flag.
- R7: Compare channel k sets status bit k+1 on the increment whose new count equals its compare value. Writing a compare register never sets a flag by itself.
- R8: Writing 1 to status bits 0–3 clears them and writing 0 leaves them unchanged. If a new event arrives in the same cycle as the clear, the flag stays set. Busy is read-only.
- R9: `irq` is high one cycle after any status bit 0–3 is set while the same bit position in the mask register (0x02) is 1.
- R10: `bus_rdata` carries the data for a read in the cycle after `bus_rd` and is 0 otherwise. Offset 0x03 and addresses 0x14–0x1F read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow count tick, one cycle wide |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The timing of each result:
- Read data appears one cycle after the read strobe.
- The counter value and any overflow or match flag change at the clock edge that takes the tick, so a read issued in the next cycle returns them.
- `irq` follows a flag one cycle later.
- A committed count appears only after the first following tick, and busy clears after the second.

The bench drives its stimulus on falling edges. A reference model updates at each rising edge, and the bench compares read data and `irq` against that model at the next falling edge. Every expected value is therefore taken exactly where the design's registers have settled.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned GRP_REGS  = 0;
  localparam int unsigned GRP_CNT   = 1;
  localparam int unsigned GRP_CMP0  = 2;
  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_STAT  = 1;
  localparam int unsigned OFF_MASK  = 2;
  localparam int unsigned STAT_BUSY = 7;

  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,
    LD_SETTLE = 2'd1,
    LD_PEND   = 2'd2
  } ld_phase_t;
endpackage

// File: rtl/sac_count_core.sv
module sac_count_core
  import sac_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          run,
  input  logic          commit,
  input  logic [CW-1:0] commit_val,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          inc_evt,
  output logic          wrap_evt,
  output logic          busy
);
  logic [CW-1:0] pend;
  ld_phase_t     phase;
  logic          load;

  always_comb begin
    load     = tick_en && (phase == LD_PEND) && !commit;
    inc_evt  = tick_en && run && !load;
    cnt_nxt  = cnt + 1'b1;
    wrap_evt = inc_evt && (cnt == '1);
    busy     = (phase != LD_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pend  <= '0;
      phase <= LD_IDLE;
    end else begin
      if (load)         cnt <= pend;
      else if (inc_evt) cnt <= cnt_nxt;
      if (commit) begin
        pend  <= commit_val;
        phase <= LD_PEND;
      end else if (tick_en) begin
        case (phase)
          LD_PEND:   phase <= LD_SETTLE;
          LD_SETTLE: phase <= LD_IDLE;
          default:   phase <= LD_IDLE;
        endcase
      end
    end
  end

  // R2: without a tick the count never moves
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt));
  // R6: a commit raises busy at once
  a_r6_busy_set: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy);
  // R6: first tick after a commit applies the pending value
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    (tick_en && phase == LD_PEND && !commit) |=> (cnt == $past(pend)));
endmodule

// File: rtl/sac_cmp_chan.sv
module sac_cmp_chan #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_commit,
  input  logic [CW-1:0] wr_val,
  input  logic          inc_evt,
  input  logic [CW-1:0] cnt_nxt,
  output logic [CW-1:0] cmp_val,
  output logic          match_evt
);
  always_ff @(posedge clk) begin
    if (rst)            cmp_val <= '0;
    else if (wr_commit) cmp_val <= wr_val;
  end

  assign match_evt = inc_evt && (cnt_nxt == cmp_val);
endmodule

// File: rtl/slow_alarm_counter.sv
module slow_alarm_counter
  import sac_pkg::*;
#(
  parameter int unsigned CW  = 32,
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int unsigned NB     = CW / BUS_W;
  localparam int unsigned OFF_W  = $clog2(NB);
  localparam int unsigned GRP_W  = AW - OFF_W;
  localparam int unsigned NFLAG  = NCH + 1;

  logic [GRP_W-1:0] grp;
  logic [OFF_W-1:0] off;
  logic             sel_regs, sel_cnt, sel_wide;
  logic [NCH-1:0]   sel_cmp, cmp_commit, match_evt;
  logic [CW-1:0]    cmp_vals [NCH];

  logic             run;
  logic [NFLAG-1:0] flags, mask, ev, clr;
  logic [CW-1:0]    temp, live, commit_val;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             inc_evt, wrap_evt, busy, cnt_commit;
  logic [BUS_W-1:0] stat_b, rd_mux;

  assign grp        = bus_addr[AW-1:OFF_W];
  assign off        = bus_addr[OFF_W-1:0];
  assign sel_regs   = (int'(grp) == GRP_REGS);
  assign sel_cnt    = (int'(grp) == GRP_CNT);
  assign sel_wide   = sel_cnt || (|sel_cmp);
  assign commit_val = {temp[CW-1:BUS_W], bus_wdata};
  assign cnt_commit = bus_wr && sel_cnt && (off == '0);

  sac_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run(run),
    .commit(cnt_commit), .commit_val(commit_val),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .inc_evt(inc_evt),
    .wrap_evt(wrap_evt), .busy(busy)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign sel_cmp[k]    = (int'(grp) == GRP_CMP0 + k);
    assign cmp_commit[k] = bus_wr && sel_cmp[k] && (off == '0);

    sac_cmp_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .wr_commit(cmp_commit[k]), .wr_val(commit_val),
      .inc_evt(inc_evt), .cnt_nxt(cnt_nxt),
      .cmp_val(cmp_vals[k]), .match_evt(match_evt[k])
    );

    // R7: a match event is recorded in its status bit
    a_r7_match: assert property (@(posedge clk) disable iff (rst)
      match_evt[k] |=> flags[k+1]);
  end

  always_comb begin
    live = cnt;
    for (int k = 0; k < NCH; k++)
      if (sel_cmp[k]) live = cmp_vals[k];
  end

  always_comb begin
    ev  = {match_evt, wrap_evt};
    clr = (bus_wr && sel_regs && int'(off) == OFF_STAT) ? bus_wdata[NFLAG-1:0] : '0;
    stat_b = '0;
    stat_b[NFLAG-1:0] = flags;
    stat_b[STAT_BUSY] = busy;
    rd_mux = '0;
    if (sel_regs) begin
      case (int'(off))
        OFF_CTRL: rd_mux[0]         = run;
        OFF_STAT: rd_mux            = stat_b;
        OFF_MASK: rd_mux[NFLAG-1:0] = mask;
        default:  rd_mux            = '0;
      endcase
    end else if (sel_wide) begin
      if (off == '0) rd_mux = live[BUS_W-1:0];
      else           rd_mux = temp[BUS_W*off +: BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      flags     <= '0;
      mask      <= '0;
      temp      <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      flags     <= (flags & ~clr) | ev;
      irq       <= |(flags & mask);
      bus_rdata <= bus_rd ? rd_mux : '0;
      if (bus_wr && sel_regs && int'(off) == OFF_CTRL) run  <= bus_wdata[0];
      if (bus_wr && sel_regs && int'(off) == OFF_MASK) mask <= bus_wdata[NFLAG-1:0];
      if (bus_wr && sel_wide && off != '0)
        temp[BUS_W*off +: BUS_W] <= bus_wdata;
      else if (bus_rd && sel_wide && off == '0)
        temp <= live;
    end
  end

  // R3: wrap sets the overflow flag
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> flags[0]);
  // R8: write-one clears the overflow flag when no new event coincides
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_regs && int'(off) == OFF_STAT && bus_wdata[0] && !wrap_evt)
      |=> !flags[0]);
  // R10: idle bus returns zero data
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/tb_slow_alarm_counter.sv
module tb_slow_alarm_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  slow_alarm_counter dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Reference model of the requirements
  logic [31:0] m_cnt, m_pend, m_temp;
  logic [31:0] m_cmp [3];
  int          m_phase;
  logic        m_en, m_irq, m_rd_q;
  logic [3:0]  m_flags, m_mask;
  logic [7:0]  m_rdata;
  logic [4:0]  m_rd_addr;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_temp = 0; m_phase = 0; m_en = 0; m_irq = 0;
      m_flags = 0; m_mask = 0; m_rdata = 0; m_rd_q = 0; m_rd_addr = 0;
      for (int k = 0; k < 3; k++) m_cmp[k] = 0;
    end else begin
      automatic int g = int'(bus_addr[4:2]);
      automatic int b = int'(bus_addr[1:0]);
      automatic logic [31:0] live = (g == 1) ? m_cnt : (g >= 2 && g <= 4) ? m_cmp[(g >= 2 && g <= 4) ? g-2 : 0] : 0;
      automatic bit wide = (g >= 1 && g <= 4);
      automatic bit cnt_commit = bus_wr && g == 1 && b == 0;
      automatic bit load = tick_en && m_phase == 2 && !cnt_commit;
      automatic bit inc = tick_en && m_en && !load;
      automatic logic [3:0] ev = 0;
      automatic logic [3:0] clr = (bus_wr && g == 0 && b == 1) ? bus_wdata[3:0] : 4'h0;
      automatic logic [31:0] nxt = m_cnt + 1;
      automatic logic [31:0] cval = {m_temp[31:8], bus_wdata};
      m_rdata = 0;
      if (bus_rd) begin
        if (g == 0) begin
          if (b == 0) m_rdata = {7'b0, m_en};
          else if (b == 1) m_rdata = {(m_phase != 0), 3'b0, m_flags};
          else if (b == 2) m_rdata = {4'b0, m_mask};
        end else if (wide) begin
          m_rdata = (b == 0) ? live[7:0] : m_temp[8*b +: 8];
        end
      end
      m_rd_q = bus_rd; m_rd_addr = bus_addr;
      if (inc) begin
        if (m_cnt == 32'hFFFF_FFFF) ev[0] = 1;
        for (int k = 0; k < 3; k++) if (nxt == m_cmp[k]) ev[k+1] = 1;
      end
      m_irq = |(m_flags & m_mask);
      m_flags = (m_flags & ~clr) | ev;
      if (load) m_cnt = m_pend; else if (inc) m_cnt = nxt;
      if (cnt_commit) begin m_pend = cval; m_phase = 2; end
      else if (tick_en && m_phase > 0) m_phase = m_phase - 1;
      if (bus_wr && g >= 2 && g <= 4 && b == 0) m_cmp[g-2] = cval;
      if (bus_wr && g == 0 && b == 0) m_en = bus_wdata[0];
      if (bus_wr && g == 0 && b == 2) m_mask = bus_wdata[3:0];
      if (bus_wr && wide && b != 0) m_temp[8*b +: 8] = bus_wdata;
      else if (bus_rd && wide && b == 0) m_temp = live;
    end
  end

  function automatic string req_of(logic [4:0] a);
    int g = int'(a[4:2]);
    if (g == 0) return (a[1:0] == 2'd1) ? "R8" : "R2";
    if (g == 1) return "R4";
    if (g <= 4) return "R7";
    return "R10";
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (m_rd_q) begin
        checks++;
        if (bus_rdata !== m_rdata) begin
          fails++;
          $display("FAIL %s/%s addr=%0h rdata actual=%0h expected=%0h",
                   tag, req_of(m_rd_addr), m_rd_addr, bus_rdata, m_rdata);
        end
      end
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s/R9 irq actual=%0b expected=%0b", tag, irq, m_irq);
      end
    end
  end

  task automatic cyc(bit w, bit r, logic [4:0] a, logic [7:0] d, bit t);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tick_en = t;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0); end
  endtask
  task automatic wr8(logic [4:0] a, logic [7:0] d); cyc(1, 0, a, d, 0); endtask
  task automatic rd8(logic [4:0] a); cyc(0, 1, a, 0, 0); endtask
  task automatic wr32(logic [4:0] base, logic [31:0] v);
    for (int i = 3; i >= 0; i--) wr8(base + 5'(i), v[8*i +: 8]);
  endtask
  task automatic rd32(logic [4:0] base);
    for (int i = 0; i < 4; i++) rd8(base + 5'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A1C_0D3E));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    tag = "R1";  for (int a = 0; a < 20; a++) rd8(5'(a));
    tag = "R10"; rd8(5'h03); rd8(5'h14); rd8(5'h1F); idle(1);
    tag = "R2";  wr8(0, 1); ticks(5); rd32(5'h04);
    wr8(0, 0); ticks(4); rd32(5'h04); rd8(0); wr8(0, 1);
    tag = "R6";  wr32(5'h04, 32'hFFFF_FFFD); rd8(1); rd32(5'h04);
    ticks(1); rd8(1); rd32(5'h04); ticks(1); rd8(1);
    tag = "R3";  ticks(3); rd8(1); rd32(5'h04);
    tag = "R8";  wr8(1, 8'h00); rd8(1); wr8(1, 8'h01); rd8(1);
    tag = "R7";  wr32(5'h08, 32'h5); wr32(5'h0C, 32'h3); wr32(5'h10, 32'h3);
    rd8(1); rd32(5'h08); rd32(5'h0C); rd32(5'h10);
    tag = "R9";  wr8(2, 8'h04); ticks(1); idle(2); rd8(1); wr8(1, 8'h0E); idle(2);
    wr8(2, 8'h0F); ticks(3); rd8(1); idle(2);
    tag = "R8";  cyc(1, 0, 5'h01, 8'h0F, 1); rd8(1); wr8(1, 8'h0F); idle(2);
    tag = "R5";  wr8(5'h07, 8'hAA); wr8(5'h06, 8'hBB); rd8(5'h08);
    wr8(5'h05, 8'hCC); wr8(5'h04, 8'hDD); ticks(2); rd32(5'h04);
    tag = "R4";  rd8(5'h0C); rd8(5'h04); rd8(5'h0D); rd8(5'h07);
    tag = "R2";
    for (int i = 0; i < 6000; i++) begin
      automatic int op = $urandom_range(0, 9);
      automatic logic [4:0] a = ($urandom_range(0, 15) == 0) ? 5'($urandom_range(20, 31))
                                                             : 5'($urandom_range(0, 19));
      automatic logic [7:0] d = 8'($urandom);
      if (a == 0) d[0] = ($urandom_range(0, 7) != 0);
      cyc(op == 0, op >= 6, a, d, $urandom_range(0, 3) == 0);
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule